// File: doc/BRIEF.md
# Interrupt In-Service Priority Tracker

This block keeps the per-vector state for a 256-vector interrupt controller. It holds three bit arrays: the requested vectors waiting for service, the vectors in service, and the trigger mode of each vector. It also keeps one cached register, `isrv`, with the highest vector in service. There is no nesting stack. The processor priority is derived from `isrv` and a task priority value that software writes. An interrupt request is raised when the best waiting vector has a higher priority class than the processor priority. An acknowledge then moves that vector into service.

An end-of-interrupt retires the vector that `isrv` names. A registered priority encoder then rescans the in-service array to find the new highest vector. The rescan looks only at vector words 1 through 7, so vectors 0 to 31 are never reported. If the retired vector was last requested as level-triggered, the block sends a one-cycle broadcast carrying that vector to the upstream source.

A vector is stored as bit `vector[4:0]` of 32-bit word `vector[7:5]`. The priority class of a vector or of a priority value is bits [7:4].

Top module: `intr_svc_tracker`

## Requirements
- R1: While reset is asserted and just after it is released, `isrv` is 0, `ppr` is 0, `intr_req` is 0 and `eoi_bcast_valid` is 0.
- R2: A cycle with `req_valid` high marks `req_vector` as waiting. `intr_req` is high when class (bits [7:4]) of the highest-numbered waiting vector is greater than class of `ppr`. While `intr_req` is high, `ack_vector` shows that vector.
- R3: An `ack` while `intr_req` is high removes the shown vector from the waiting set and puts it in service. From the next cycle on, `isrv` equals that vector.
- R4: `ppr` equals the task priority when class(task priority) is at least class(`isrv`). Otherwise `ppr` equals `isrv` with bits [3:0] cleared. `ppr` follows a change of either input one cycle later.
- R5: A cycle with `tpr_we` high loads `tpr_wdata` as the task priority. `ppr` reflects it one cycle after the write.
- R6: A waiting vector goes into service only if its class is strictly higher than class(`isrv`). A waiting vector of the same class stays waiting and raises no request.
- R7: An `eoi` while `isrv` is nonzero retires that vector from service. One cycle later `isrv` holds the highest vector still in service among 32 to 255, or 0 if there is none. `ppr` follows one cycle after that.
- R8: An `eoi` while `isrv` is 0 changes nothing and produces no broadcast.
- R9: Vectors 0 to 31 left in service are never reported by the rescan. When only such vectors remain, `isrv` becomes 0 and later EOIs are gratuitous.
- R10: When the retired vector was last requested with `req_level` = 1, `eoi_bcast_valid` is high for exactly one cycle, right after the EOI edge, and `eoi_bcast_vector` equals the retired vector. If it was last requested with `req_level` = 0, no pulse is sent.
- R11: `intr_req` is low in the cycle after an accept or a task priority write. It is also low during the EOI rescan cycle and the cycle after it.
- R12: An `ack` in the same cycle as `eoi` is ignored. The EOI alone takes effect.
- R13: A request for the same vector in the same cycle that the vector is accepted leaves it both in service and waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| intr_req | output | 1 | Deliverable interrupt present |
| ack | input | 1 | Acknowledge: accept the shown vector |
| ack_vector | output | 8 | Best waiting vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast_valid | output | 1 | Level-triggered EOI broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector retired by the broadcast EOI |
| ppr | output | 8 | Processor priority |
| isrv | output | 8 | Highest vector in service |

## Verification
A long random mix of requests, acknowledges, EOIs and task priority writes builds nesting of varying depth. This shows whether the strict-class rule, the rescan after each EOI and the priority formula stay consistent with a bench model across many states. Directed patterns then target specific behaviour:
- same-class requests, which separate a strict from a non-strict comparison;
- a low vector left in service under a higher one, which shows whether the rescan wrongly includes word 0;
- EOIs of level and edge vectors, which separate broadcast from silence;
- acknowledges that coincide with an EOI or with a request of the same vector, which expose the wrong precedence.

// File: rtl/isvc_pkg.sv
package isvc_pkg;
   localparam int unsigned ISVC_CLS_W = 4;

   typedef enum logic {
      RET_IDLE = 1'b0,
      RET_SCAN = 1'b1
   } isvc_ret_e;
endpackage

// File: rtl/isvc_hi_find.sv
module isvc_hi_find #(
   parameter  int unsigned NUM_WORDS = 8,
   parameter  int unsigned WORD_W    = 32,
   parameter  int unsigned LO_WORD   = 0,
   localparam int unsigned POS_W     = $clog2(WORD_W),
   localparam int unsigned WIDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned IDX_W     = POS_W + WIDX_W
) (
   input  logic [NUM_WORDS*WORD_W-1:0] bits,
   output logic                        found,
   output logic [IDX_W-1:0]            idx
);
   if (NUM_WORDS < 2) begin : g_chk_words
      $error("isvc_hi_find: NUM_WORDS must be at least 2");
   end
   if (LO_WORD >= NUM_WORDS) begin : g_chk_lo
      $error("isvc_hi_find: LO_WORD out of range");
   end

   logic [NUM_WORDS-1:0]            w_any;
   logic [NUM_WORDS-1:0][POS_W-1:0] w_pos;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      if (w < LO_WORD) begin : g_skip
         assign w_any[w] = 1'b0;
         assign w_pos[w] = '0;
      end else begin : g_scan
         logic [WORD_W-1:0] word;
         logic [POS_W-1:0]  pos;
         assign word = bits[w*WORD_W +: WORD_W];
         always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
               if (word[b]) pos = POS_W'(b);
            end
         end
         assign w_any[w] = |word;
         assign w_pos[w] = pos;
      end
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (w_any[w]) begin
            found = 1'b1;
            idx   = {WIDX_W'(w), w_pos[w]};
         end
      end
   end
endmodule

// File: rtl/isvc_ppr_calc.sv
module isvc_ppr_calc #(
   parameter  int unsigned VEC_W = 8,
   parameter  int unsigned CLS_W = 4,
   localparam int unsigned SUB_W = VEC_W - CLS_W
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic [VEC_W-1:0] isrv,
   output logic [VEC_W-1:0] ppr
);
   if (CLS_W == 0 || CLS_W >= VEC_W) begin : g_chk_cls
      $error("isvc_ppr_calc: CLS_W must lie in 1..VEC_W-1");
   end

   logic [CLS_W-1:0] tpr_cls;
   logic [CLS_W-1:0] isv_cls;
   assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
   assign isv_cls = isrv[VEC_W-1 -: CLS_W];

   always_comb begin
      if (tpr_cls >= isv_cls) ppr = tpr;
      else                    ppr = {isv_cls, {SUB_W{1'b0}}};
   end
endmodule

// File: rtl/isvc_state_bank.sv
module isvc_state_bank #(
   parameter  int unsigned NUM_VEC = 256,
   localparam int unsigned VEC_W   = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [VEC_W-1:0]   set_vec,
   input  logic               set_level,
   input  logic               acc_en,
   input  logic [VEC_W-1:0]   acc_vec,
   input  logic               ret_en,
   input  logic [VEC_W-1:0]   ret_vec,
   output logic [NUM_VEC-1:0] irr,
   output logic [NUM_VEC-1:0] isr,
   output logic [NUM_VEC-1:0] tmr
);
   logic [NUM_VEC-1:0] set_mask;
   logic [NUM_VEC-1:0] acc_mask;
   logic [NUM_VEC-1:0] ret_mask;

   assign set_mask = NUM_VEC'(set_en) << set_vec;
   assign acc_mask = NUM_VEC'(acc_en) << acc_vec;
   assign ret_mask = NUM_VEC'(ret_en) << ret_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr <= '0;
         isr <= '0;
         tmr <= '0;
      end else begin
         irr <= (irr & ~acc_mask) | set_mask;
         isr <= (isr | acc_mask) & ~ret_mask;
         if (set_level) tmr <= tmr | set_mask;
         else           tmr <= tmr & ~set_mask;
      end
   end

   // R13: a new request wins over a same-cycle accept of that vector
   p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> irr[$past(set_vec)]);

   p_accept_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !(ret_en && ret_vec == acc_vec)) |=> isr[$past(acc_vec)]);
endmodule

// File: rtl/intr_svc_tracker.sv
module intr_svc_tracker #(
   parameter  int unsigned NUM_VEC      = 256,
   parameter  int unsigned WORD_W       = 32,
   parameter  int unsigned CLS_W        = isvc_pkg::ISVC_CLS_W,
   parameter  int unsigned SCAN_LO_WORD = 1,
   localparam int unsigned VEC_W        = $clog2(NUM_VEC),
   localparam int unsigned NUM_WORDS    = NUM_VEC / WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vector,
   input  logic             req_level,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   output logic             intr_req,
   input  logic             ack,
   output logic [VEC_W-1:0] ack_vector,
   input  logic             eoi,
   output logic             eoi_bcast_valid,
   output logic [VEC_W-1:0] eoi_bcast_vector,
   output logic [VEC_W-1:0] ppr,
   output logic [VEC_W-1:0] isrv
);
   import isvc_pkg::*;

   if ((1 << VEC_W) != NUM_VEC) begin : g_chk_pow2
      $error("intr_svc_tracker: NUM_VEC must be a power of two");
   end
   if (NUM_VEC % WORD_W != 0) begin : g_chk_word
      $error("intr_svc_tracker: NUM_VEC must be a multiple of WORD_W");
   end
   if (SCAN_LO_WORD >= NUM_WORDS) begin : g_chk_scan
      $error("intr_svc_tracker: SCAN_LO_WORD out of range");
   end

   logic [NUM_VEC-1:0] irr, isr, tmr;
   logic               pend_found, scan_found;
   logic [VEC_W-1:0]   pend_vec, scan_vec;
   logic [VEC_W-1:0]   tpr_q, isrv_q, ppr_q, ppr_next;
   logic               ppr_dirty;
   isvc_ret_e          ret_q;
   logic               busy, accept, eoi_go;
   logic               bcast_q;
   logic [VEC_W-1:0]   bcast_vec_q;
   logic [CLS_W-1:0]   pend_cls, ppr_cls, isrv_cls, tpr_cls;

   isvc_state_bank #(.NUM_VEC(NUM_VEC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(req_valid), .set_vec(req_vector), .set_level(req_level),
      .acc_en(accept), .acc_vec(pend_vec),
      .ret_en(eoi_go), .ret_vec(isrv_q),
      .irr(irr), .isr(isr), .tmr(tmr)
   );

   isvc_hi_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .LO_WORD(0)) u_pend_find (
      .bits(irr), .found(pend_found), .idx(pend_vec)
   );

   isvc_hi_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .LO_WORD(SCAN_LO_WORD)) u_scan_find (
      .bits(isr), .found(scan_found), .idx(scan_vec)
   );

   isvc_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
      .tpr(tpr_q), .isrv(isrv_q), .ppr(ppr_next)
   );

   assign pend_cls = pend_vec[VEC_W-1 -: CLS_W];
   assign ppr_cls  = ppr_q[VEC_W-1 -: CLS_W];
   assign isrv_cls = isrv_q[VEC_W-1 -: CLS_W];
   assign tpr_cls  = tpr_q[VEC_W-1 -: CLS_W];

   assign busy     = ppr_dirty | (ret_q == RET_SCAN);
   assign intr_req = pend_found && (pend_cls > ppr_cls) && !busy;
   assign accept   = ack && intr_req && !eoi;
   assign eoi_go   = eoi && (ret_q == RET_IDLE) && (isrv_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q       <= '0;
         isrv_q      <= '0;
         ppr_q       <= '0;
         ppr_dirty   <= 1'b0;
         ret_q       <= RET_IDLE;
         bcast_q     <= 1'b0;
         bcast_vec_q <= '0;
      end else begin
         if (tpr_we) tpr_q <= tpr_wdata;
         if (accept)                  isrv_q <= pend_vec;
         else if (ret_q == RET_SCAN)  isrv_q <= scan_found ? scan_vec : '0;
         ret_q     <= eoi_go ? RET_SCAN : RET_IDLE;
         ppr_dirty <= accept | tpr_we | (ret_q == RET_SCAN);
         ppr_q     <= ppr_next;
         bcast_q   <= eoi_go && tmr[isrv_q];
         if (eoi_go) bcast_vec_q <= isrv_q;
      end
   end

   assign ack_vector       = pend_found ? pend_vec : '0;
   assign ppr              = ppr_q;
   assign isrv             = isrv_q;
   assign eoi_bcast_valid  = bcast_q;
   assign eoi_bcast_vector = bcast_vec_q;

   p_req_above_ppr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      intr_req |-> (pend_found && pend_cls > ppr_cls));

   p_accept_loads_isrv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> isrv_q == $past(pend_vec));

   p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ppr_cls >= tpr_cls && ppr_cls >= isrv_cls));

   p_strict_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> pend_cls > isrv_cls);

   p_gratuitous_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isrv_q == '0 && ret_q == RET_IDLE && !ack) |=> (!bcast_q && $stable(isrv_q)));

   p_scan_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_q == RET_SCAN) |=> (isrv_q == '0 || isrv_q >= VEC_W'(SCAN_LO_WORD * WORD_W)));

   p_bcast_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_q |=> !bcast_q);

   p_quiet_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept || tpr_we) |=> !intr_req);

   p_eoi_blocks_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && ack && isrv_q == '0 && ret_q == RET_IDLE) |=> isrv_q == '0);
endmodule

// File: tb/intr_svc_tracker_bench.sv
module intr_svc_tracker_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_level = 1'b0, tpr_we = 1'b0, ack = 1'b0, eoi = 1'b0;
   logic [7:0] req_vector = '0, tpr_wdata = '0;
   logic       intr_req, eoi_bcast_valid;
   logic [7:0] ack_vector, eoi_bcast_vector, ppr, isrv;

   int n_checks = 0;
   int n_errors = 0;

   bit      m_irr [256];
   bit      m_isr [256];
   bit      m_tmr [256];
   int      m_isrv = 0;
   int      m_tpr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_svc_tracker u_intr_svc_tracker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .intr_req(intr_req), .ack(ack), .ack_vector(ack_vector),
      .eoi(eoi), .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector),
      .ppr(ppr), .isrv(isrv)
   );

   function automatic int m_hi_pend();
      for (int i = 255; i >= 0; i--) if (m_irr[i]) return i;
      return -1;
   endfunction

   function automatic int m_scan();
      for (int i = 255; i >= 32; i--) if (m_isr[i]) return i;
      return 0;
   endfunction

   function automatic int m_ppr();
      if ((m_tpr >> 4) >= (m_isrv >> 4)) return m_tpr;
      return m_isrv & 8'hF0;
   endfunction

   function automatic bit m_req();
      int p;
      p = m_hi_pend();
      return (p >= 0) && ((p >> 4) > (m_ppr() >> 4));
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic check_all(string tag);
      bit er;
      er = m_req();
      chk(intr_req == er, tag, "intr_req (R2)", int'(intr_req), int'(er));
      if (er) chk(int'(ack_vector) == m_hi_pend(), tag, "ack_vector (R2)", int'(ack_vector), m_hi_pend());
      chk(int'(isrv) == m_isrv, tag, "isrv (R3 R7)", int'(isrv), m_isrv);
      chk(int'(ppr) == m_ppr(), tag, "ppr (R4)", int'(ppr), m_ppr());
   endtask

   task automatic do_req(int v, bit lvl);
      @(negedge clk);
      req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
      m_irr[v] = 1'b1; m_tmr[v] = lvl;
      check_all("R2");
   endtask

   task automatic do_tpr(int t);
      @(negedge clk);
      tpr_we = 1'b1; tpr_wdata = 8'(t);
      @(negedge clk);
      tpr_we = 1'b0;
      m_tpr = t;
      chk(intr_req == 1'b0, "R11", "intr_req after priority write", int'(intr_req), 0);
      settle();
      check_all("R5");
   endtask

   // with_req: drive a same-vector request alongside the acknowledge (R13)
   task automatic do_ack(bit with_req, bit lvl);
      bit exp; int p;
      exp = m_req(); p = m_hi_pend();
      @(negedge clk);
      ack = 1'b1;
      if (with_req && p >= 0) begin
         req_valid = 1'b1; req_vector = 8'(p); req_level = lvl;
      end
      @(negedge clk);
      ack = 1'b0; req_valid = 1'b0;
      if (exp) begin
         m_irr[p] = 1'b0; m_isr[p] = 1'b1; m_isrv = p;
         chk(intr_req == 1'b0, "R11", "intr_req after accept", int'(intr_req), 0);
         chk(int'(isrv) == p, "R3", "isrv right after accept", int'(isrv), p);
      end
      if (with_req && p >= 0) begin m_irr[p] = 1'b1; m_tmr[p] = lvl; end
      settle();
      check_all("R3");
   endtask

   task automatic do_eoi(bit with_ack);
      bit exp_b; int old;
      old = m_isrv;
      exp_b = (old != 0) && m_tmr[old];
      @(negedge clk);
      eoi = 1'b1; ack = with_ack;
      @(negedge clk);
      eoi = 1'b0; ack = 1'b0;
      chk(eoi_bcast_valid == exp_b, "R10", "broadcast valid", int'(eoi_bcast_valid), int'(exp_b));
      if (exp_b) chk(int'(eoi_bcast_vector) == old, "R10", "broadcast vector", int'(eoi_bcast_vector), old);
      if (old != 0) begin
         chk(intr_req == 1'b0, "R11", "intr_req during rescan", int'(intr_req), 0);
         m_isr[old] = 1'b0;
         m_isrv = m_scan();
      end
      @(negedge clk);
      chk(eoi_bcast_valid == 1'b0, "R10", "broadcast one cycle", int'(eoi_bcast_valid), 0);
      settle();
      check_all(old != 0 ? "R7" : "R8");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd7741);
      repeat (3) @(negedge clk);
      chk(intr_req == 1'b0 && eoi_bcast_valid == 1'b0 && isrv == 8'd0 && ppr == 8'd0,
          "R1", "outputs in reset", int'({intr_req, eoi_bcast_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: highest-numbered waiting vector wins
      do_req(8'h35, 1'b0);
      do_req(8'h72, 1'b1);
      do_ack(1'b0, 1'b0);
      // R6: same class as the vector in service stays waiting
      do_req(8'h7A, 1'b0);
      chk(intr_req == 1'b0, "R6", "same-class request", int'(intr_req), 0);
      do_tpr(8'h85);
      do_tpr(8'h20);
      do_eoi(1'b0);               // level 0x72 retires: broadcast (R10)
      do_ack(1'b0, 1'b0);         // 0x7A
      do_eoi(1'b0);               // edge: no broadcast (R10)
      do_ack(1'b0, 1'b0);         // 0x35
      do_eoi(1'b0);
      do_eoi(1'b0);               // R8 gratuitous

      // R9: a low vector left in service is invisible to the rescan
      do_tpr(8'h00);
      do_req(8'h18, 1'b1);
      do_ack(1'b0, 1'b0);
      do_req(8'h50, 1'b0);
      do_ack(1'b0, 1'b0);
      do_eoi(1'b0);
      chk(isrv == 8'd0, "R9", "isrv after rescan", int'(isrv), 0);
      do_eoi(1'b0);               // gratuitous: 0x18 stays, no pulse

      // R12: acknowledge with EOI in the same cycle is ignored
      do_req(8'h90, 1'b0);
      do_eoi(1'b1);
      chk(intr_req == 1'b1, "R12", "request still raised", int'(intr_req), 1);
      // R13: same-vector request during accept
      do_ack(1'b1, 1'b1);
      chk(intr_req == 1'b0, "R13", "re-request below ppr", int'(intr_req), 0);
      do_eoi(1'b0);
      chk(int'(ack_vector) == 8'h90 && intr_req, "R13", "vector waiting again", int'(ack_vector), 8'h90);
      do_ack(1'b0, 1'b0);
      do_eoi(1'b0);

      // R11 / R5: request blocked by priority, released by a write
      do_tpr(8'hF0);
      do_req(8'h60, 1'b0);
      do_tpr(8'h00);

      for (int i = 0; i < 400; i++) begin
         r = $urandom % 8;
         if (r < 3)      do_req(16 + int'($urandom % 240), 1'($urandom));
         else if (r < 6) do_ack(1'b0, 1'b0);
         else if (r < 7) do_eoi(1'b0);
         else            do_tpr(int'((($urandom % 7) << 4) | ($urandom % 16)));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule